// File: doc/BRIEF.md
# Video Bus Address Decoder with Character-Bank Mirroring

This block sits between a CPU-side video bus and two targets: the video memory array and the control register file. It takes one request per cycle, keeps only the low 19 bits of the address, and steers the request to the target that owns that address. It drives a select strobe and a target-local address, and forwards the write flag, byte-lane enables, access size and write data with it. Addresses that belong to no target produce no strobe.

The top 32 KiB of the decoded space is a folded view of character memory. Four 8 KiB character banks sit in video memory at a stride of 32 KiB. In the window they appear as one contiguous block. Address bits 14:13 of the window pick the bank, and they are moved up to bits 16:15 of the memory address.

Reads always return a response. The targets answer in the cycle after their strobe, and the block registers the data of the selected target as the response. A read that hits no target still returns a response, with zero data.

Top module: `video_bus_decoder`

## Requirements
- R1: After reset, `vram_sel`, `reg_sel` and `rsp_valid` are all low.
- R2: Only address bits 18:0 take part in decoding. Bits 31:19 have no effect on the region or on the target address.
- R3: A request with a masked address below 0x40000 raises `vram_sel` one cycle later, with `vram_addr` equal to address bits 17:0.
- R4: A request with a masked address from 0x5E000 to 0x5FFFF raises `reg_sel` one cycle later, with `reg_addr` equal to address bits 12:0. At most one of the two selects is high in any cycle.
- R5: A write to 0x40000–0x5DFFF or 0x60000–0x77FFF raises no strobe.
- R6: A request with a masked address of 0x78000 or above raises `vram_sel` one cycle later. Here `vram_addr` = 0x06000 | (address bits 14:13 placed at bits 16:15) | address bits 12:0.
- R7: A read to an unmapped address returns `rsp_valid` high with `rsp_data` equal to zero.
- R8: Every read returns exactly one `rsp_valid` pulse, two cycles after the request, one cycle after the strobe. It carries the data of the selected target from the strobe cycle. A write returns no response.
- R9: With each strobe, `vram_we`/`reg_we`, `tgt_be`, `tgt_size` and `tgt_wdata` carry the request's values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address; only bits 18:0 are decoded |
| req_be | input | 4 | Byte-lane enables |
| req_size | input | 2 | Access size code, passed through |
| req_wdata | input | 32 | Write data |
| vram_sel | output | 1 | Video memory strobe |
| vram_we | output | 1 | Video memory write flag |
| vram_addr | output | 18 | Translated video memory address |
| reg_sel | output | 1 | Register file strobe |
| reg_we | output | 1 | Register file write flag |
| reg_addr | output | 13 | Register file offset |
| tgt_be | output | 4 | Byte-lane enables to the selected target |
| tgt_size | output | 2 | Access size to the selected target |
| tgt_wdata | output | 32 | Write data to the selected target |
| vram_rdata | input | 32 | Video memory read data, valid the cycle after its strobe |
| reg_rdata | input | 32 | Register file read data, valid the cycle after its strobe |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Read response data |

## Verification
The hardest case is a back-to-back mix in which a mirror-window read, an unmapped read and a register read follow each other in consecutive cycles. Each response must then take its data from the target chosen two cycles earlier, even though the target strobes have already moved on. The bench issues requests on every cycle with no idle gaps, so response data from different regions overlap in the pipeline. The models of both targets return data derived from the address they receive, so a wrong fold or a wrong source selection shows up as a data mismatch. Requests with high address bits set check that masking is applied before region boundaries are compared.

// File: rtl/vbdec_pkg.sv
package vbdec_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_VRAM = 2'd1,
    RGN_REG  = 2'd2
  } region_e;
endpackage

// File: rtl/vbdec_region.sv
// Combinational classification of a bus address and translation into the
// target-local address space, including the character-bank fold.
module vbdec_region
  import vbdec_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DEC_W   = 19,
  parameter int VRAM_AW = 18,
  parameter int REG_AW  = 13,
  parameter int BANK_AW = 13,
  parameter int BANK_SW = 2,
  parameter logic [DEC_W-1:0]   VRAM_TOP    = 19'h40000,
  parameter logic [DEC_W-1:0]   REG_BASE    = 19'h5E000,
  parameter logic [DEC_W-1:0]   REG_TOP     = 19'h60000,
  parameter logic [DEC_W-1:0]   MIRROR_BASE = 19'h78000,
  parameter logic [VRAM_AW-1:0] FOLD_BASE   = 18'h06000
) (
  input  logic [ADDR_W-1:0]  addr,
  output region_e            region,
  output logic [VRAM_AW-1:0] vram_addr,
  output logic [REG_AW-1:0]  reg_addr
);
  localparam logic [ADDR_W-1:0] KEEP_MASK = ADDR_W'((64'd1 << DEC_W) - 64'd1);
  localparam logic [ADDR_W-1:0] VRAM_TOP_W = ADDR_W'(VRAM_TOP);
  localparam logic [ADDR_W-1:0] REG_BASE_W = ADDR_W'(REG_BASE);
  localparam logic [ADDR_W-1:0] REG_TOP_W  = ADDR_W'(REG_TOP);
  localparam logic [ADDR_W-1:0] MIR_BASE_W = ADDR_W'(MIRROR_BASE);
  localparam int FOLD_SHIFT = BANK_AW + BANK_SW;

  logic [ADDR_W-1:0]  masked;
  logic               in_direct, in_reg, in_mirror;
  logic [VRAM_AW-1:0] fold_addr;

  always_comb begin
    masked    = addr & KEEP_MASK;
    in_direct = masked < VRAM_TOP_W;
    in_reg    = (masked >= REG_BASE_W) && (masked < REG_TOP_W);
    in_mirror = masked >= MIR_BASE_W;
    fold_addr = FOLD_BASE
              | (VRAM_AW'(masked[BANK_AW +: BANK_SW]) << FOLD_SHIFT)
              | VRAM_AW'(masked[BANK_AW-1:0]);
    vram_addr = in_mirror ? fold_addr : masked[VRAM_AW-1:0];
    reg_addr  = masked[REG_AW-1:0];
    if (in_direct || in_mirror) region = RGN_VRAM;
    else if (in_reg)            region = RGN_REG;
    else                        region = RGN_NONE;
  end
endmodule

// File: rtl/vbdec_issue.sv
// Registered issue stage: target strobes, addresses and pass-through fields.
module vbdec_issue
  import vbdec_pkg::*;
#(
  parameter int VRAM_AW = 18,
  parameter int REG_AW  = 13,
  parameter int DATA_W  = 32,
  parameter int SIZE_W  = 2,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_we,
  input  region_e            region,
  input  logic [VRAM_AW-1:0] vram_addr_d,
  input  logic [REG_AW-1:0]  reg_addr_d,
  input  logic [BE_W-1:0]    req_be,
  input  logic [SIZE_W-1:0]  req_size,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               vram_sel,
  output logic               vram_we,
  output logic [VRAM_AW-1:0] vram_addr,
  output logic               reg_sel,
  output logic               reg_we,
  output logic [REG_AW-1:0]  reg_addr,
  output logic [BE_W-1:0]    tgt_be,
  output logic [SIZE_W-1:0]  tgt_size,
  output logic [DATA_W-1:0]  tgt_wdata,
  output logic               rd_pend,
  output region_e            rd_src
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vram_sel <= 1'b0;
      reg_sel  <= 1'b0;
      vram_we  <= 1'b0;
      reg_we   <= 1'b0;
      rd_pend  <= 1'b0;
      rd_src   <= RGN_NONE;
    end else begin
      vram_sel <= req_valid && (region == RGN_VRAM);
      reg_sel  <= req_valid && (region == RGN_REG);
      vram_we  <= req_valid && (region == RGN_VRAM) && req_we;
      reg_we   <= req_valid && (region == RGN_REG) && req_we;
      rd_pend  <= req_valid && !req_we;
      rd_src   <= region;
    end
  end

  always_ff @(posedge clk) begin
    vram_addr <= vram_addr_d;
    reg_addr  <= reg_addr_d;
    tgt_be    <= req_be;
    tgt_size  <= req_size;
    tgt_wdata <= req_wdata;
  end

  // R9: a strobe is only ever the consequence of a request one cycle earlier
  a_r9_strobe_from_request: assert property (@(posedge clk) disable iff (rst)
    (vram_sel || reg_sel) |-> $past(req_valid));
endmodule

// File: rtl/vbdec_rsp.sv
// Response stage: registers the data of the target addressed in the strobe cycle.
module vbdec_rsp
  import vbdec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_pend,
  input  region_e           rd_src,
  input  logic [DATA_W-1:0] vram_rdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic [DATA_W-1:0] pick;

  always_comb begin
    unique case (rd_src)
      RGN_VRAM: pick = vram_rdata;
      RGN_REG:  pick = reg_rdata;
      default:  pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_pend;
      rsp_data  <= rd_pend ? pick : '0;
    end
  end

  // R8: responses follow a pending read from the issue stage
  a_r8_rsp_after_pending: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(rd_pend));
endmodule

// File: rtl/video_bus_decoder.sv
module video_bus_decoder
  import vbdec_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DEC_W   = 19,
  parameter int VRAM_AW = 18,
  parameter int REG_AW  = 13,
  parameter int DATA_W  = 32,
  parameter int SIZE_W  = 2,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_we,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [BE_W-1:0]    req_be,
  input  logic [SIZE_W-1:0]  req_size,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               vram_sel,
  output logic               vram_we,
  output logic [VRAM_AW-1:0] vram_addr,
  output logic               reg_sel,
  output logic               reg_we,
  output logic [REG_AW-1:0]  reg_addr,
  output logic [BE_W-1:0]    tgt_be,
  output logic [SIZE_W-1:0]  tgt_size,
  output logic [DATA_W-1:0]  tgt_wdata,
  input  logic [DATA_W-1:0]  vram_rdata,
  input  logic [DATA_W-1:0]  reg_rdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data
);
  localparam logic [DEC_W-1:0] MIRROR_BASE = 19'h78000;

  region_e            region;
  logic [VRAM_AW-1:0] vram_addr_d;
  logic [REG_AW-1:0]  reg_addr_d;
  logic               rd_pend;
  region_e            rd_src;

  vbdec_region #(
    .ADDR_W(ADDR_W), .DEC_W(DEC_W), .VRAM_AW(VRAM_AW), .REG_AW(REG_AW),
    .MIRROR_BASE(MIRROR_BASE)
  ) u_region (
    .addr(req_addr), .region(region), .vram_addr(vram_addr_d), .reg_addr(reg_addr_d)
  );

  vbdec_issue #(
    .VRAM_AW(VRAM_AW), .REG_AW(REG_AW), .DATA_W(DATA_W), .SIZE_W(SIZE_W)
  ) u_issue (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we), .region(region),
    .vram_addr_d(vram_addr_d), .reg_addr_d(reg_addr_d), .req_be(req_be),
    .req_size(req_size), .req_wdata(req_wdata), .vram_sel(vram_sel), .vram_we(vram_we),
    .vram_addr(vram_addr), .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
    .tgt_be(tgt_be), .tgt_size(tgt_size), .tgt_wdata(tgt_wdata),
    .rd_pend(rd_pend), .rd_src(rd_src)
  );

  vbdec_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst(rst), .rd_pend(rd_pend), .rd_src(rd_src),
    .vram_rdata(vram_rdata), .reg_rdata(reg_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // R4: never two targets at once
  a_r4_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({vram_sel, reg_sel}));

  // R5: unmapped writes leave both targets untouched
  a_r5_unmapped_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_we && region == RGN_NONE) |=> (!vram_sel && !reg_sel));

  // R6: mirror window lands in the folded bank with the offset preserved
  a_r6_mirror_fold: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr[DEC_W-1:0] >= MIRROR_BASE) |=>
      (vram_sel && vram_addr[12:0] == $past(req_addr[12:0]) && vram_addr[14:13] == 2'b11));

  // R7: unmapped reads answer with zero
  a_r7_unmapped_read_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_we && region == RGN_NONE) |=> ##1 (rsp_valid && rsp_data == '0));

  // R8: a response is always the answer to a read two cycles back
  a_r8_rsp_from_read: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_we, 2));
endmodule

// File: tb/test_video_bus_decoder.sv
module test_video_bus_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        vram_sel, vram_we, reg_sel, reg_we, rsp_valid;
  logic [17:0] vram_addr;
  logic [12:0] reg_addr;
  logic [3:0]  tgt_be;
  logic [1:0]  tgt_size;
  logic [31:0] tgt_wdata, vram_rdata, reg_rdata, rsp_data;

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // target models: data derived from the address each target receives
  assign vram_rdata = 32'hA500_0000 | {14'd0, vram_addr};
  assign reg_rdata  = 32'h3C00_0000 | {19'd0, reg_addr};

  video_bus_decoder i_video_bus_decoder (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_be(req_be), .req_size(req_size), .req_wdata(req_wdata),
    .vram_sel(vram_sel), .vram_we(vram_we), .vram_addr(vram_addr),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
    .tgt_be(tgt_be), .tgt_size(tgt_size), .tgt_wdata(tgt_wdata),
    .vram_rdata(vram_rdata), .reg_rdata(reg_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  typedef struct {
    int          due;
    int          tgt;   // 0 none, 1 video memory, 2 register file
    logic        we;
    logic [17:0] va;
    logic [12:0] ra;
    logic [3:0]  be;
    logic [1:0]  sz;
    logic [31:0] wd;
    string       tag;
  } strobe_t;

  typedef struct {
    int          due;
    logic        present;
    logic [31:0] data;
    string       tag;
  } resp_t;

  strobe_t sq[$];
  resp_t   rq[$];
  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic we, input logic [3:0] be,
                       input logic [1:0] sz, input logic [31:0] wd, input string tag);
    strobe_t s;
    resp_t   r;
    int      m;
    m = int'(a & 32'h7FFFF);
    s.tgt = 0; s.va = '0; s.ra = '0;
    if (m < 'h40000) begin
      s.tgt = 1; s.va = 18'(m);
    end else if (m >= 'h5E000 && m < 'h60000) begin
      s.tgt = 2; s.ra = 13'(m - 'h5E000);
    end else if (m >= 'h78000) begin
      s.tgt = 1; s.va = 18'((((m >> 13) & 3) << 15) | 'h6000 | (m & 'h1FFF));
    end
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_be = be; req_size = sz; req_wdata = wd;
    s.due = cyc + 1; s.we = we; s.be = be; s.sz = sz; s.wd = wd; s.tag = tag;
    sq.push_back(s);
    r.due = cyc + 2; r.present = !we; r.tag = tag;
    r.data = (s.tgt == 1) ? (32'hA500_0000 | {14'd0, s.va}) :
             (s.tgt == 2) ? (32'h3C00_0000 | {19'd0, s.ra}) : 32'h0;
    rq.push_back(r);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0; req_we = 1'b0;
    end
  endtask

  // monitor: compare outputs against the scoreboard queues
  always @(negedge clk) begin
    if (!rst) begin
      if (sq.size() > 0 && sq[0].due == cyc) begin
        strobe_t s;
        s = sq.pop_front();
        if (s.tgt == 0) begin
          check(!vram_sel && !reg_sel, s.tag, "no strobe", {62'd0, vram_sel, reg_sel}, 64'd0);
        end else if (s.tgt == 1) begin
          check(vram_sel && !reg_sel, s.tag, "vram strobe", {62'd0, vram_sel, reg_sel}, 64'd2);
          check(vram_addr == s.va, s.tag, "vram_addr", 64'(vram_addr), 64'(s.va));
          check(vram_we == s.we, "R9", "vram_we", 64'(vram_we), 64'(s.we));
        end else begin
          check(reg_sel && !vram_sel, s.tag, "reg strobe", {62'd0, vram_sel, reg_sel}, 64'd1);
          check(reg_addr == s.ra, s.tag, "reg_addr", 64'(reg_addr), 64'(s.ra));
          check(reg_we == s.we, "R9", "reg_we", 64'(reg_we), 64'(s.we));
        end
        if (s.tgt != 0) begin
          check(tgt_be == s.be && tgt_size == s.sz, "R9", "be/size",
                {58'd0, tgt_be, tgt_size}, {58'd0, s.be, s.sz});
          if (s.we) check(tgt_wdata == s.wd, "R9", "wdata", 64'(tgt_wdata), 64'(s.wd));
        end
      end else if (vram_sel || reg_sel) begin
        check(1'b0, "R4", "unexpected strobe", {62'd0, vram_sel, reg_sel}, 64'd0);
      end
      if (rq.size() > 0 && rq[0].due == cyc) begin
        resp_t r;
        r = rq.pop_front();
        check(rsp_valid == r.present, "R8", {r.tag, " rsp_valid"}, 64'(rsp_valid), 64'(r.present));
        if (r.present) check(rsp_data == r.data, r.tag, "rsp_data", 64'(rsp_data), 64'(r.data));
      end else if (rsp_valid) begin
        check(1'b0, "R8", "unexpected response", 64'(rsp_valid), 64'd0);
      end
    end
  end

  initial begin
    #(4 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!vram_sel && !reg_sel && !rsp_valid, "R1", "reset outputs",
          {61'd0, vram_sel, reg_sel, rsp_valid}, 64'd0);
    // back-to-back reads across every boundary
    issue(32'h0000_0000, 1'b0, 4'hF, 2'd2, 32'h0, "R3");
    issue(32'h0003_FFFF, 1'b0, 4'h1, 2'd0, 32'h0, "R3");
    issue(32'h0004_0000, 1'b0, 4'hF, 2'd2, 32'h0, "R7");
    issue(32'h0005_E000, 1'b0, 4'h3, 2'd1, 32'h0, "R4");
    issue(32'h0007_A123, 1'b0, 4'hF, 2'd2, 32'h0, "R6");
    issue(32'h0005_DFFF, 1'b0, 4'h8, 2'd0, 32'h0, "R7");
    issue(32'h0005_FFFF, 1'b0, 4'h8, 2'd0, 32'h0, "R4");
    issue(32'h0006_0000, 1'b0, 4'hF, 2'd2, 32'h0, "R7");
    issue(32'h0007_7FFF, 1'b0, 4'h8, 2'd0, 32'h0, "R7");
    issue(32'h0007_8000, 1'b0, 4'hF, 2'd2, 32'h0, "R6");
    issue(32'h0007_FFFF, 1'b0, 4'h8, 2'd0, 32'h0, "R6");
    issue(32'h0001_2345, 1'b0, 4'h2, 2'd0, 32'h0, "R3");
    issue(32'hFFF0_0010, 1'b0, 4'hF, 2'd2, 32'h0, "R2");
    issue(32'h8007_C002, 1'b0, 4'hF, 2'd2, 32'h0, "R2");
    issue(32'h1235_E010, 1'b0, 4'hF, 2'd2, 32'h0, "R2");
    idle(2);
    // writes: pass-through fields and dropped unmapped writes
    issue(32'h0000_0100, 1'b1, 4'b0101, 2'd1, 32'hDEAD_BEEF, "R9");
    issue(32'h0004_5000, 1'b1, 4'hF, 2'd2, 32'h1111_2222, "R5");
    issue(32'h0005_E004, 1'b1, 4'b1100, 2'd1, 32'hCAFE_0042, "R9");
    issue(32'h0006_ABCD, 1'b1, 4'hF, 2'd2, 32'h3333_4444, "R5");
    issue(32'h0007_D000, 1'b1, 4'b0010, 2'd0, 32'h0000_5A00, "R6");
    issue(32'hA005_0000, 1'b1, 4'hF, 2'd2, 32'h5555_6666, "R5");
    issue(32'h0005_C000, 1'b0, 4'hF, 2'd2, 32'h0, "R7");
    idle(6);
    check(sq.size() == 0 && rq.size() == 0, "R8", "queues drained",
          64'(sq.size() + rq.size()), 64'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule